// File: doc/BRIEF.md
# Two-Wire Bus Stuck-Low Watchdog and Clock-Out Recovery

This block supervises a two-wire bus that an upstream port shares with a set of downstream channels, two by default. While monitoring, every downstream channel whose enable is high is connected to the upstream side, in any combination. A cycle counter runs while the synchronized upstream data and clock lines are not both high. Any cycle in which both lines are high restarts it. If the count reaches the configured timeout, the bus is considered stuck low. This check runs only while the detection-enable input is high.

When the bus is found stuck, the block raises a fault flag. It cuts the upstream side away from every channel that was enabled at that moment. It then drives a burst of open-drain pull-low pulses on the clock line of each cut channel, so that a target holding data low can finish its byte and let go. The burst on a channel ends early once that channel's data line is seen high at the end of a clock-high phase. It never exceeds a fixed pulse count. After all bursts end, the block waits until the upstream lines and the lines of every cut channel are high. It then clears the fault and reconnects each channel whose enable is still high.

Top module: `bus_unstick_ctrl`

## Requirements
- R1: After reset the fault flag is low, no clock pull-low request is active, and each channel's connect output equals its enable.
- R2: While monitoring, ch_connect_o[i] follows ch_en_i[i] for every combination of enables.
- R3: With detection enabled and the upstream lines never both high, fault_o rises after TIMEOUT_CYC cycles plus the synchronizer and register delay (a few cycles). It does not rise before TIMEOUT_CYC cycles.
- R4: A cycle with both synchronized upstream lines high restarts the timeout count. Periodic idle moments spaced closer than TIMEOUT_CYC therefore never raise the fault.
- R5: While unstick_en_i is low, no stuck condition is declared, whatever the bus levels: fault_o stays low, connects follow enables, and no pull-low occurs.
- R6: When the fault rises, every channel that was enabled is disconnected in the same cycle. A channel that was not enabled gets no pull-low pulses.
- R7: Each recovery pulse holds ch_scl_pull_o high for HALF_PERIOD cycles, followed by HALF_PERIOD released cycles. A channel receives at most MAX_PULSES pulses per event.
- R8: A channel's burst ends after the first pulse at whose high-phase end the channel's data line reads high. A channel released after its Nth pulse therefore receives exactly N pulses.
- R9: The fault clears only after all bursts end and the upstream lines and every cut channel's lines read high. A cut channel then reconnects only if its enable is high at that time.
- R10: A channel's clock pull-low request is never active while that channel is connected.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| up_sda_i | input | 1 | Upstream data line level |
| up_scl_i | input | 1 | Upstream clock line level |
| dn_sda_i | input | NUM_CH | Data line level of each downstream channel |
| dn_scl_i | input | NUM_CH | Clock line level of each downstream channel |
| ch_en_i | input | NUM_CH | Per-channel connection enable |
| unstick_en_i | input | 1 | Enables stuck detection and disconnection |
| ch_connect_o | output | NUM_CH | Per-channel connect control for the buffer |
| ch_scl_pull_o | output | NUM_CH | Per-channel open-drain clock pull-low request |
| fault_o | output | 1 | Stuck-bus fault flag |

## Verification
A timer that counts wrongly or misses its restart shows up within one timeout window: the fault flag rises too early, too late, or during periodic idle moments. A faulty clock-out engine shows up on the pull-low outputs within one burst, as wrong pulse widths, a pulse count that overruns the limit, or a burst that continues after the data line is released. A controller stuck in the wrong state shows up as a fault that never clears, or a connect output that ignores its enable after recovery, within a few cycles of the lines going idle.

// File: rtl/unstick_pkg.sv
package unstick_pkg;
   typedef enum logic [1:0] {
      ST_WATCH    = 2'd0,
      ST_CLOCKOUT = 2'd1,
      ST_SETTLE   = 2'd2
   } ctl_state_e;
endpackage

// File: rtl/unstick_sync.sv
module unstick_sync #(
   parameter int unsigned W      = 1,
   parameter int unsigned STAGES = 2
) (
   input  logic         clk_i,
   input  logic         rst_ni,
   input  logic [W-1:0] d_i,
   output logic [W-1:0] q_o
);
   generate
      if (STAGES == 0) begin : g_bypass
         assign q_o = d_i;
      end else begin : g_chain
         logic [STAGES-1:0][W-1:0] pipe_q;
         always_ff @(posedge clk_i or negedge rst_ni) begin
            if (!rst_ni) begin
               pipe_q <= '1;
            end else begin
               pipe_q[0] <= d_i;
               for (int s = 1; s < STAGES; s++) begin
                  pipe_q[s] <= pipe_q[s-1];
               end
            end
         end
         assign q_o = pipe_q[STAGES-1];
      end
   endgenerate
endmodule

// File: rtl/unstick_idle_timer.sv
module unstick_idle_timer #(
   parameter int unsigned LIMIT = 4500000
) (
   input  logic clk_i,
   input  logic rst_ni,
   input  logic arm_i,
   input  logic idle_i,
   output logic expire_o
);
   localparam int unsigned CW = (LIMIT > 1) ? $clog2(LIMIT) : 1;
   localparam logic [CW-1:0] LAST = CW'(LIMIT - 1);

   logic [CW-1:0] cnt_q;

   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
         cnt_q <= '0;
      end else if (!arm_i || idle_i) begin
         cnt_q <= '0;
      end else if (cnt_q != LAST) begin
         cnt_q <= cnt_q + 1'b1;
      end
   end

   assign expire_o = arm_i && !idle_i && (cnt_q == LAST);

   // R4
   restart_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (arm_i && idle_i) |=> (cnt_q == '0));

   // R3
   expire_arm_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      expire_o |-> $past(arm_i && !idle_i));
endmodule

// File: rtl/unstick_clkgen.sv
module unstick_clkgen #(
   parameter int unsigned HALF_PERIOD = 500,
   parameter int unsigned MAX_PULSES  = 16
) (
   input  logic clk_i,
   input  logic rst_ni,
   input  logic start_i,
   input  logic sda_i,
   output logic pull_o,
   output logic busy_o
);
   localparam int unsigned HW = (HALF_PERIOD > 1) ? $clog2(HALF_PERIOD) : 1;
   localparam int unsigned PW = $clog2(MAX_PULSES + 1);
   localparam logic [HW-1:0] PH_LAST = HW'(HALF_PERIOD - 1);
   localparam logic [PW-1:0] P_MAX   = PW'(MAX_PULSES);

   logic          busy_q;
   logic          low_q;
   logic [HW-1:0] ph_q;
   logic [PW-1:0] pulses_q;
   logic          ph_end;

   assign ph_end = (ph_q == PH_LAST);

   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
         busy_q   <= 1'b0;
         low_q    <= 1'b0;
         ph_q     <= '0;
         pulses_q <= '0;
      end else if (!busy_q) begin
         if (start_i) begin
            busy_q   <= 1'b1;
            low_q    <= 1'b1;
            ph_q     <= '0;
            pulses_q <= PW'(1);
         end
      end else if (!ph_end) begin
         ph_q <= ph_q + 1'b1;
      end else begin
         ph_q <= '0;
         if (low_q) begin
            low_q <= 1'b0;
         end else if (sda_i || (pulses_q == P_MAX)) begin
            busy_q <= 1'b0;
         end else begin
            low_q    <= 1'b1;
            pulses_q <= pulses_q + 1'b1;
         end
      end
   end

   assign pull_o = busy_q && low_q;
   assign busy_o = busy_q;

   // R7
   pulse_bound_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      busy_q |-> (pulses_q <= P_MAX));

   // R7
   phase_range_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      busy_q |-> (ph_q <= PH_LAST));

   // R8
   early_stop_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (busy_q && !low_q && ph_end && sda_i) |=> !busy_o);
endmodule

// File: rtl/bus_unstick_ctrl.sv
module bus_unstick_ctrl
   import unstick_pkg::*;
#(
   parameter int unsigned NUM_CH      = 2,
   parameter int unsigned TIMEOUT_CYC = 4500000,
   parameter int unsigned HALF_PERIOD = 500,
   parameter int unsigned MAX_PULSES  = 16,
   parameter int unsigned SYNC_STAGES = 2
) (
   input  logic              clk_i,
   input  logic              rst_ni,
   input  logic              up_sda_i,
   input  logic              up_scl_i,
   input  logic [NUM_CH-1:0] dn_sda_i,
   input  logic [NUM_CH-1:0] dn_scl_i,
   input  logic [NUM_CH-1:0] ch_en_i,
   input  logic              unstick_en_i,
   output logic [NUM_CH-1:0] ch_connect_o,
   output logic [NUM_CH-1:0] ch_scl_pull_o,
   output logic              fault_o
);
   localparam int unsigned SW = 2 + 2 * NUM_CH;

   generate
      if (NUM_CH < 1) begin : g_bad_ch
         $error("NUM_CH must be at least 1");
      end
      if (TIMEOUT_CYC < 2) begin : g_bad_to
         $error("TIMEOUT_CYC must be at least 2");
      end
      if (HALF_PERIOD < 2) begin : g_bad_half
         $error("HALF_PERIOD must be at least 2");
      end
      if (MAX_PULSES < 1) begin : g_bad_pulses
         $error("MAX_PULSES must be at least 1");
      end
   endgenerate

   logic [SW-1:0]     raw_vec;
   logic [SW-1:0]     syn_vec;
   logic              s_up_sda;
   logic              s_up_scl;
   logic [NUM_CH-1:0] s_dn_sda;
   logic [NUM_CH-1:0] s_dn_scl;

   assign raw_vec = {dn_scl_i, dn_sda_i, up_scl_i, up_sda_i};

   unstick_sync #(
      .W      (SW),
      .STAGES (SYNC_STAGES)
   ) sync_i (
      .clk_i  (clk_i),
      .rst_ni (rst_ni),
      .d_i    (raw_vec),
      .q_o    (syn_vec)
   );

   assign s_up_sda = syn_vec[0];
   assign s_up_scl = syn_vec[1];
   assign s_dn_sda = syn_vec[2 +: NUM_CH];
   assign s_dn_scl = syn_vec[2 + NUM_CH +: NUM_CH];

   ctl_state_e        state_q;
   ctl_state_e        state_d;
   logic [NUM_CH-1:0] cut_q;
   logic              fault_q;
   logic              up_idle;
   logic              trip;
   logic [NUM_CH-1:0] start_vec;
   logic [NUM_CH-1:0] busy_vec;
   logic [NUM_CH-1:0] chan_idle;
   logic              settled;

   assign up_idle = s_up_sda && s_up_scl;

   unstick_idle_timer #(
      .LIMIT (TIMEOUT_CYC)
   ) timer_i (
      .clk_i    (clk_i),
      .rst_ni   (rst_ni),
      .arm_i    (unstick_en_i && (state_q == ST_WATCH)),
      .idle_i   (up_idle),
      .expire_o (trip)
   );

   assign start_vec = {NUM_CH{trip}} & ch_en_i;

   generate
      for (genvar c = 0; c < NUM_CH; c++) begin : g_chan
         unstick_clkgen #(
            .HALF_PERIOD (HALF_PERIOD),
            .MAX_PULSES  (MAX_PULSES)
         ) clkgen_i (
            .clk_i   (clk_i),
            .rst_ni  (rst_ni),
            .start_i (start_vec[c]),
            .sda_i   (s_dn_sda[c]),
            .pull_o  (ch_scl_pull_o[c]),
            .busy_o  (busy_vec[c])
         );

         assign chan_idle[c] = s_dn_sda[c] && s_dn_scl[c];

         // R10
         pull_isolated_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
            ch_scl_pull_o[c] |-> !ch_connect_o[c]);
      end
   endgenerate

   assign settled = up_idle && (&(chan_idle | ~cut_q));

   always_comb begin
      state_d = state_q;
      unique case (state_q)
         ST_WATCH:    if (trip)        state_d = ST_CLOCKOUT;
         ST_CLOCKOUT: if (busy_vec == '0) state_d = ST_SETTLE;
         ST_SETTLE:   if (settled)     state_d = ST_WATCH;
         default:                      state_d = ST_WATCH;
      endcase
   end

   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
         state_q <= ST_WATCH;
         cut_q   <= '0;
         fault_q <= 1'b0;
      end else begin
         state_q <= state_d;
         if (state_q == ST_WATCH && trip) begin
            cut_q   <= ch_en_i;
            fault_q <= 1'b1;
         end else if (state_q == ST_SETTLE && settled) begin
            cut_q   <= '0;
            fault_q <= 1'b0;
         end
      end
   end

   assign ch_connect_o = ch_en_i & ~cut_q;
   assign fault_o      = fault_q;

   // R5
   nodetect_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      ((state_q == ST_WATCH) && !unstick_en_i) |=> !fault_o);

   // R6
   cut_on_fault_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      $rose(fault_o) |-> ((ch_connect_o & $past(ch_en_i)) == '0));

   // R9
   clear_idle_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      $fell(fault_o) |-> $past(up_idle && (busy_vec == '0)));
endmodule

// File: tb/bus_unstick_ctrl_tb.sv
module bus_unstick_ctrl_tb_top;
   localparam int CLK_PERIOD = 10;
   localparam int TO    = 200;
   localparam int HALF  = 8;
   localparam int MAXP  = 16;
   localparam int WDOG  = 150000;

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       m_sda = 1'b1;
   logic       m_scl = 1'b1;
   logic [1:0] tgt_hold = 2'b00;
   logic [1:0] ch_en = 2'b11;
   logic       unstick_en = 1'b1;
   logic [1:0] connect;
   logic [1:0] pull;
   logic       fault;
   logic       up_sda;
   logic       up_scl;
   logic [1:0] dn_sda;
   logic [1:0] dn_scl;

   int errs = 0;
   int checks = 0;
   int cyc = 0;
   bit done = 0;
   int pcnt [2] = '{0, 0};
   int pbase [2] = '{0, 0};
   int rel_at [2] = '{1000, 1000};
   logic [1:0] pull_prev = 2'b00;

   always #(CLK_PERIOD / 2) clk = ~clk;

   assign up_sda = m_sda & ~(|(connect & tgt_hold));
   assign up_scl = m_scl;
   assign dn_sda = ~tgt_hold & ~(connect & {2{~m_sda}});
   assign dn_scl = ~pull & ~(connect & {2{~m_scl}});

   bus_unstick_ctrl #(
      .NUM_CH      (2),
      .TIMEOUT_CYC (TO),
      .HALF_PERIOD (HALF),
      .MAX_PULSES  (MAXP),
      .SYNC_STAGES (2)
   ) dut_i (
      .clk_i         (clk),
      .rst_ni        (rst_n),
      .up_sda_i      (up_sda),
      .up_scl_i      (up_scl),
      .dn_sda_i      (dn_sda),
      .dn_scl_i      (dn_scl),
      .ch_en_i       (ch_en),
      .unstick_en_i  (unstick_en),
      .ch_connect_o  (connect),
      .ch_scl_pull_o (pull),
      .fault_o       (fault)
   );

   // pulse counter and target model: a target lets go of data after rel_at pulses
   always @(posedge clk) begin
      cyc <= cyc + 1;
      pull_prev <= pull;
      for (int i = 0; i < 2; i++) begin
         if (pull[i] && !pull_prev[i]) pcnt[i] <= pcnt[i] + 1;
         if (tgt_hold[i] && (pcnt[i] - pbase[i] >= rel_at[i]) && !pull[i])
            tgt_hold[i] <= 1'b0;
      end
   end

   task automatic chk(input string req, input int act, input int exp);
      checks++;
      if (act != exp) begin
         errs++;
         $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
      end
   endtask

   task automatic wait_cyc(input int n);
      for (int k = 0; k < n; k++) @(negedge clk);
   endtask

   task automatic mark_pulses();
      pbase[0] = pcnt[0];
      pbase[1] = pcnt[1];
   endtask

   task automatic wait_fault_clear(input int limit);
      for (int k = 0; k < limit && fault; k++) @(negedge clk);
   endtask

   task automatic t_reset();
      rst_n = 1'b0;
      wait_cyc(3);
      rst_n = 1'b1;
      wait_cyc(2);
      chk("R1 fault after reset", fault, 0);
      chk("R1 pull after reset", pull, 0);
      chk("R1 connect after reset", connect, 3);
   endtask

   task automatic t_enables();
      for (int m = 0; m < 4; m++) begin
         ch_en = m[1:0];
         wait_cyc(1);
         chk("R2 connect follows enables", connect, m);
      end
      ch_en = 2'b11;
   endtask

   task automatic t_detect_off();
      unstick_en = 1'b0;
      m_sda = 1'b0;
      m_scl = 1'b0;
      wait_cyc(3 * TO);
      chk("R5 no fault while disabled", fault, 0);
      chk("R5 connect kept while disabled", connect, 3);
      chk("R5 no pull while disabled", pull, 0);
      m_sda = 1'b1;
      m_scl = 1'b1;
      wait_cyc(5);
      unstick_en = 1'b1;
   endtask

   task automatic t_keepalive();
      for (int r = 0; r < 5; r++) begin
         m_sda = 1'b0;
         m_scl = 1'b0;
         wait_cyc(TO - 30);
         m_sda = 1'b1;
         m_scl = 1'b1;
         wait_cyc(4);
      end
      chk("R4 idle moments restart timer", fault, 0);
      chk("R4 no pull during keepalive", pull, 0);
   endtask

   task automatic t_release_early();
      ch_en = 2'b11;
      rel_at[0] = 5;
      rel_at[1] = 1000;
      mark_pulses();
      tgt_hold = 2'b01;
      wait_cyc(TO - 10);
      chk("R3 no fault before timeout", fault, 0);
      wait_cyc(20);
      chk("R3 fault after timeout", fault, 1);
      chk("R6 enabled channels cut", connect, 0);
      wait_fault_clear(2000);
      chk("R8 pulses on held channel", pcnt[0] - pbase[0], 5);
      chk("R8 single pulse on free channel", pcnt[1] - pbase[1], 1);
      chk("R9 fault cleared after recovery", fault, 0);
      chk("R9 channels reconnected", connect, 3);
      rel_at[0] = 1000;
   endtask

   task automatic t_stuck_forever();
      int width;
      ch_en = 2'b10;
      rel_at[1] = 1000;
      wait_cyc(2);
      mark_pulses();
      tgt_hold = 2'b10;
      wait_cyc(TO + 10);
      chk("R3 fault on channel 1 stuck", fault, 1);
      while (pull[1]) @(negedge clk);
      while (!pull[1]) @(negedge clk);
      width = 0;
      while (pull[1]) begin
         width++;
         @(negedge clk);
      end
      chk("R7 pull-low width", width, HALF);
      wait_cyc(2 * HALF * MAXP + 50);
      chk("R7 burst capped", pcnt[1] - pbase[1], MAXP);
      chk("R6 disabled channel not pulsed", pcnt[0] - pbase[0], 0);
      chk("R6 disabled channel stays off", connect, 0);
      chk("R9 fault held while data low", fault, 1);
      ch_en = 2'b00;
      tgt_hold = 2'b00;
      wait_cyc(20);
      chk("R9 fault clears once lines idle", fault, 0);
      chk("R9 no reconnect when enable dropped", connect, 0);
      ch_en = 2'b10;
      wait_cyc(1);
      chk("R2 connect returns with enable", connect, 2);
      ch_en = 2'b11;
   endtask

   initial begin
      t_reset();
      t_enables();
      t_detect_off();
      t_keepalive();
      t_release_early();
      t_stuck_forever();
      wait_cyc(5);
      if (!done) begin
         done = 1;
         $display("Result: errors=%0d of %0d checks", errs, checks);
         $finish;
      end
   end

   always @(negedge clk) begin
      if (cyc > WDOG && !done) begin
         done = 1;
         checks++;
         errs++;
         $display("FAIL watchdog: actual=%0d expected<%0d cycles", cyc, WDOG);
         $display("Result: errors=%0d of %0d checks", errs, checks);
         $finish;
      end
   end
endmodule